// File: doc/BRIEF.md
# Banked Frame Buffer Handoff Controller

This block stands between a producer that fills an image frame and a host that drains it through a bus bridge. Three identical memory banks, each 32K words of 16 bits, are joined into one linear space of 96K words. The upper two address bits choose a bank and the lower fifteen choose the word inside it. Each accepted producer write drives exactly one bank select, plus the in-bank address and the data, in the same cycle.

The controller counts the accepted writes of the current frame. A full frame is 320 x 240 pixels of two bytes, which is 76,800 words. When that count is reached, ownership of the buffer moves to the host. The host interrupt is then raised and held until the host acknowledges that it has read the frame. Until that acknowledge, the producer cannot write. A single ownership flag tells the producer who holds the buffer.

The producer side is a valid/ready port. `wr_ready` is high only while the producer owns the buffer. A write beat is taken when `wr_valid` and `wr_ready` are both high. A beat offered while `wr_ready` is low is not held for later; it is discarded and recorded in a sticky overrun flag that the host clears. A producer that must not lose data therefore waits for `wr_ready` (or `prod_own`) before presenting a beat.

Top module: `fbuf_handoff_ctrl`

## Requirements
- R1: Immediately after reset, `wr_ready`=1, `prod_own`=1, `host_irq`=0, `overrun`=0, and no bank select is active.
- R2: For an accepted write whose `wr_addr[16:15]` is 0, 1 or 2, exactly `bank_cs` bit 0, 1 or 2 (respectively) is high in that same cycle, with `bank_we`=1, `bank_addr`=`wr_addr[14:0]` and `bank_wdata`=`wr_data`. Without an accepted write, `bank_cs`=0 and `bank_we`=0.
- R3: An accepted write with `wr_addr[16:15]`=3 asserts no bank select and no `bank_we`, but it still counts toward the frame.
- R4: On the clock edge that accepts the FRAME_WORDS-th write of a frame, control passes to the host. From the next cycle, `host_irq`=1, `prod_own`=0 and `wr_ready`=0.
- R5: While the host owns the buffer, `host_irq` stays high, and no bank select or write enable is driven whatever the producer presents.
- R6: `host_ack` high while the host owns the buffer returns ownership to the producer on the next cycle (`host_irq`=0, `prod_own`=1) and restarts the write count from zero, so another FRAME_WORDS writes are needed for the next interrupt.
- R7: A beat with `wr_valid`=1 and `wr_ready`=0 is dropped and sets `overrun` from the next cycle on. `overrun` stays set until a cycle with `ovr_clr`=1 and no new dropped beat, after which it reads 0. A drop in the same cycle as `ovr_clr` keeps it set.
- R8: `host_ack` while the producer owns the buffer is ignored: the write count is kept, and the interrupt follows exactly FRAME_WORDS accepted writes after the previous handoff.
- R9: `prod_own` is high exactly when `host_irq` is low, and `wr_ready` equals `prod_own`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Producer offers a write beat |
| wr_ready | output | 1 | Beat will be accepted (producer owns buffer) |
| wr_addr | input | 17 | Linear word address: bank in [16:15], word in [14:0] |
| wr_data | input | 16 | Write data |
| bank_cs | output | 3 | One-hot bank select for the accepted write |
| bank_we | output | 1 | Write enable to the selected bank |
| bank_addr | output | 15 | Word address inside the bank |
| bank_wdata | output | 16 | Data to the bank |
| host_irq | output | 1 | Frame-ready interrupt, held until acknowledge |
| host_ack | input | 1 | Host has read the frame |
| ovr_clr | input | 1 | Host clears the overrun flag |
| overrun | output | 1 | Sticky: a beat was dropped while host owned the buffer |
| prod_own | output | 1 | Ownership flag: 1 = producer may write |

## Verification
The assertions assume that every input has a defined 0/1 value at each rising edge after reset. They also assume that the host acknowledge is a level sampled on the edge, not a pulse that has to be caught. The stimulus changes all inputs only on the falling edge, always to defined values. It mixes random beats over the full 17-bit address (so the illegal bank code appears about a quarter of the time) with random acknowledges and clears. Directed cases cover a stray acknowledge in mid-frame, a drop that coincides with a clear, and a write offered on the very cycle of handoff.

// File: rtl/fbh_pkg.sv
package fbh_pkg;
  typedef enum logic {
    OWN_PRODUCER = 1'b0,
    OWN_HOST     = 1'b1
  } fbh_owner_e;

  function automatic int unsigned sel_width(input int unsigned banks);
    return (banks > 1) ? $clog2(banks) : 1;
  endfunction
endpackage

// File: rtl/fbh_bank_decode.sv
module fbh_bank_decode #(
  parameter int unsigned BANK_AW   = 15,
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned SEL_W     = fbh_pkg::sel_width(NUM_BANKS),
  parameter int unsigned ADDR_W    = BANK_AW + SEL_W
) (
  input  logic                 en,
  input  logic [ADDR_W-1:0]    lin_addr,
  output logic [NUM_BANKS-1:0] cs,
  output logic                 we,
  output logic [BANK_AW-1:0]   word_addr
);
  logic [SEL_W-1:0] sel;

  assign sel       = lin_addr[ADDR_W-1:BANK_AW];
  assign word_addr = lin_addr[BANK_AW-1:0];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cs
    assign cs[g] = en && (sel == SEL_W'(g));
  end

  assign we = |cs;

  always_comb begin
    assert ($onehot0(cs)) else $error("AST_CS_ONEHOT"); // R2
  end
endmodule

// File: rtl/fbh_frame_fsm.sv
module fbh_frame_fsm #(
  parameter int unsigned FRAME_WORDS = 76800,
  parameter int unsigned CNT_W       = $clog2(FRAME_WORDS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_valid,
  input  logic host_ack,
  input  logic ovr_clr,
  output logic wr_fire,
  output logic prod_own,
  output logic host_irq,
  output logic overrun
);
  import fbh_pkg::*;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_WORDS - 1);

  fbh_owner_e       owner_q;
  logic [CNT_W-1:0] cnt_q;
  logic             drop;

  assign prod_own = (owner_q == OWN_PRODUCER);
  assign host_irq = (owner_q == OWN_HOST);
  assign wr_fire  = wr_valid && prod_own;
  assign drop     = wr_valid && !prod_own;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= OWN_PRODUCER;
      cnt_q   <= '0;
    end else begin
      unique case (owner_q)
        OWN_PRODUCER: begin
          if (wr_fire) begin
            if (cnt_q == LAST) owner_q <= OWN_HOST;
            cnt_q <= cnt_q + 1'b1;
          end
        end
        OWN_HOST: begin
          if (host_ack) begin
            owner_q <= OWN_PRODUCER;
            cnt_q   <= '0;
          end
        end
        default: owner_q <= OWN_PRODUCER;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       overrun <= 1'b0;
    else if (drop)    overrun <= 1'b1;
    else if (ovr_clr) overrun <= 1'b0;
  end

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq && !host_ack |=> host_irq) else $error("AST_IRQ_HOLD"); // R5
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq && host_ack |=> prod_own && !host_irq) else $error("AST_ACK_RELEASE"); // R6
  AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> $past(wr_fire)) else $error("AST_IRQ_AFTER_WRITE"); // R4
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !ovr_clr |=> overrun) else $error("AST_OVR_STICKY"); // R7
  AST_DROP_SETS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && host_irq |=> overrun) else $error("AST_DROP_SETS_OVR"); // R7
endmodule

// File: rtl/fbuf_handoff_ctrl.sv
module fbuf_handoff_ctrl #(
  parameter int unsigned BANK_AW     = 15,
  parameter int unsigned NUM_BANKS   = 3,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned FRAME_WORDS = 76800,
  parameter int unsigned SEL_W       = fbh_pkg::sel_width(NUM_BANKS),
  parameter int unsigned ADDR_W      = BANK_AW + SEL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [NUM_BANKS-1:0] bank_cs,
  output logic                 bank_we,
  output logic [BANK_AW-1:0]   bank_addr,
  output logic [DATA_W-1:0]    bank_wdata,
  output logic                 host_irq,
  input  logic                 host_ack,
  input  logic                 ovr_clr,
  output logic                 overrun,
  output logic                 prod_own
);
  logic wr_fire;

  fbh_frame_fsm #(.FRAME_WORDS(FRAME_WORDS)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .host_ack (host_ack),
    .ovr_clr  (ovr_clr),
    .wr_fire  (wr_fire),
    .prod_own (prod_own),
    .host_irq (host_irq),
    .overrun  (overrun)
  );

  fbh_bank_decode #(.BANK_AW(BANK_AW), .NUM_BANKS(NUM_BANKS)) u_dec (
    .en        (wr_fire),
    .lin_addr  (wr_addr),
    .cs        (bank_cs),
    .we        (bank_we),
    .word_addr (bank_addr)
  );

  assign wr_ready   = prod_own;
  assign bank_wdata = wr_data;

  AST_HOST_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> (bank_cs == '0) && !bank_we) else $error("AST_HOST_NO_CS"); // R5
  AST_ILLEGAL_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr[ADDR_W-1:BANK_AW] >= SEL_W'(NUM_BANKS)) |-> (bank_cs == '0)) else $error("AST_ILLEGAL_BANK"); // R3
  AST_OWN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    prod_own != host_irq) else $error("AST_OWN_EXCL"); // R9
endmodule

// File: tb/fbuf_handoff_ctrl_tb.sv
module fbuf_handoff_ctrl_tb;
  localparam int FW = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, host_ack = 1'b0, ovr_clr = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        wr_ready, bank_we, host_irq, overrun, prod_own;
  logic [2:0]  bank_cs;
  logic [14:0] bank_addr;
  logic [15:0] bank_wdata;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_cnt = 0;
  bit m_host = 0, m_ovr = 0;

  always #2.5 clk = ~clk;

  fbuf_handoff_ctrl #(.FRAME_WORDS(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .bank_cs(bank_cs), .bank_we(bank_we),
    .bank_addr(bank_addr), .bank_wdata(bank_wdata), .host_irq(host_irq),
    .host_ack(host_ack), .ovr_clr(ovr_clr), .overrun(overrun), .prod_own(prod_own)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_cs(input bit v, input bit host, input logic [16:0] a);
    if (!v || host || a[16:15] == 2'd3) return 3'b000;
    return 3'b001 << a[16:15];
  endfunction

  task automatic check_regs(input string req);
    chk(req, "host_irq", host_irq, m_host);
    chk("R9", "prod_own", prod_own, !m_host);
    chk("R9", "wr_ready", wr_ready, !m_host);
    chk("R7", "overrun", overrun, m_ovr);
  endtask

  // Called at a falling edge: drive, check same-cycle outputs, clock, check registered outputs.
  task automatic step(input bit v, input logic [16:0] a, input logic [15:0] d,
                      input bit ack, input bit clr, input string req);
    logic [2:0] ecs;
    wr_valid = v; wr_addr = a; wr_data = d; host_ack = ack; ovr_clr = clr;
    #1;
    ecs = exp_cs(v, m_host, a);
    chk(m_host ? "R5" : (a[16:15] == 2'd3 ? "R3" : "R2"), "bank_cs", bank_cs, ecs);
    chk("R2", "bank_we", bank_we, |ecs);
    if (|ecs) begin
      chk("R2", "bank_addr", bank_addr, a[14:0]);
      chk("R2", "bank_wdata", bank_wdata, d);
    end
    @(posedge clk);
    if (v && m_host) m_ovr = 1;
    else if (clr) m_ovr = 0;
    if (!m_host) begin
      if (v) begin
        m_cnt++;
        if (m_cnt == FW) m_host = 1;
      end
    end else if (ack) begin
      m_host = 0; m_cnt = 0;
    end
    @(negedge clk);
    check_regs(req);
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "bank_cs", bank_cs, 0);
    check_regs("R1");
    rst_n = 1;
    @(negedge clk);
    check_regs("R1");

    // R2/R3: directed bank walk, then finish frame
    step(1, {2'd0, 15'h0000}, 16'h1111, 0, 0, "R2");
    step(1, {2'd1, 15'h7fff}, 16'h2222, 0, 0, "R2");
    step(1, {2'd2, 15'h1234}, 16'h3333, 0, 0, "R2");
    step(1, {2'd3, 15'h0042}, 16'h4444, 0, 0, "R3");
    // R8: stray acknowledge mid-frame must not restart the count
    step(0, '0, '0, 1, 0, "R8");
    step(1, {2'd0, 15'h0005}, 16'h5555, 1, 0, "R8");
    for (int i = 0; i < FW - 6; i++) step(1, 17'($urandom), 16'($urandom), 0, 0, "R8");
    chk("R4", "irq before last word", host_irq, 0);
    step(1, 17'($urandom), 16'($urandom), 0, 0, "R4");
    chk("R4", "irq after last word", host_irq, 1);
    // R5/R7: host owns; drop, hold, drop with clear
    step(0, '0, '0, 0, 0, "R5");
    step(1, {2'd1, 15'h0001}, 16'hdead, 0, 0, "R7");
    step(0, '0, '0, 0, 0, "R7");
    step(1, {2'd2, 15'h0002}, 16'hbeef, 0, 1, "R7");
    step(0, '0, '0, 0, 1, "R7");
    chk("R7", "overrun cleared", overrun, 0);
    // R6: acknowledge returns ownership, count restarts
    step(0, '0, '0, 1, 0, "R6");
    for (int i = 0; i < FW - 1; i++) step(1, 17'($urandom), 16'($urandom), 0, 0, "R6");
    chk("R6", "irq one short", host_irq, 0);
    step(1, '0, 16'h0abc, 0, 0, "R6");
    chk("R6", "irq full frame", host_irq, 1);
    step(0, '0, '0, 1, 0, "R6");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(99);
      step(r < 75, 17'($urandom), 16'($urandom),
           $urandom_range(99) < (m_host ? 15 : 5),
           $urandom_range(99) < 8, "R4");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule